// File: doc/BRIEF.md
# Accumulator Byte Operation Unit

This block is the byte-wide execution core of a small accumulator machine. It holds one working register W, a carry flag, a zero flag and a small array of file bytes. On a start strobe, the selected operation reads the file byte at the given address and combines it with W. A destination bit then sends the result either into W or back into that same file byte. The whole operation takes one clock.

The operations are: copy the file byte, add it to W, add it to W with the stored carry, decrement it, and load a literal into W. The carry that an add leaves behind feeds the next add-with-carry, so values wider than a byte can be summed one byte at a time. Fetching instructions, decoding instruction words and forming bank addresses are done outside this block.

Top module: `acc_byte_unit`

## Requirements
- R1: After reset, W, carry, zero, result and done are all 0, and every file byte reads back as 0.
- R2: `done` is high for exactly the one cycle after each clock edge that samples `start` high, whatever the opcode, and is low at all other times.
- R3: Opcode 0 (move) with `dest`=0 copies file[`faddr`] into W. With `dest`=1 it rewrites the same byte, so both the file byte and W keep their values.
- R4: Opcode 1 (add) forms W + file[`faddr`]. `carry` takes the bit that leaves bit 7. `dest`=0 writes the low byte to W and leaves the file byte unchanged. `dest`=1 writes it to the file byte and leaves W unchanged.
- R5: Opcode 2 (add with carry) forms W + file[`faddr`] + the stored carry. Its carry and destination handling are the same as for opcode 1.
- R6: Opcode 3 (decrement) forms file[`faddr`] − 1 modulo 256 (0 becomes 0xFF). `dest`=0 writes it to W and leaves the file byte unchanged. `dest`=1 writes it to the file byte and leaves W unchanged.
- R7: Opcodes 0, 3 and 4 leave `carry` unchanged.
- R8: For every opcode 0–4, `zero` becomes 1 when the 8-bit result is 0x00, and 0 otherwise.
- R9: Opcode 4 (literal load) writes `imm` into W whatever the value of `dest`, and leaves every file byte unchanged.
- R10: Opcodes 5–7, and cycles without `start`, change none of W, carry, zero, result or any file byte.
- R11: `result` shows the 8-bit result of the most recent operation with opcode 0–4, one cycle after its start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts one operation on this edge |
| op | input | 3 | Opcode: 0 move, 1 add, 2 add with carry, 3 decrement, 4 literal load |
| faddr | input | ADDR_W (4) | Address of the file byte used as the operand |
| dest | input | 1 | Destination: 0 = W, 1 = file byte |
| imm | input | DATA_W (8) | Literal for opcode 4 |
| w_out | output | DATA_W (8) | Working register W |
| result | output | DATA_W (8) | Result of the last defined operation |
| carry | output | 1 | Carry flag |
| zero | output | 1 | Zero flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle: the start-to-done pulse, carry kept by the non-add opcodes, zero agreeing with the result, the W update of a plain add, W kept on file-destination operations, and the full hold on idle or undefined cycles. Other effects can only be shown by the bench's scenarios. These are the write-back into the file array, the carry chaining across several add-with-carry steps, and the decrement wrap from 0x00. Each of them shows up at the ports only when the byte is later read back with a move.

// File: rtl/acc_unit_pkg.sv
package acc_unit_pkg;

   typedef enum logic [2:0] {
      OP_MOV  = 3'd0,
      OP_ADD  = 3'd1,
      OP_ADDC = 3'd2,
      OP_DEC  = 3'd3,
      OP_LDW  = 3'd4
   } acc_op_e;

   localparam int OP_W = 3;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
   import acc_unit_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit HAS_ADDC = 1'b1
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] w_i,
   input  logic [DATA_W-1:0] f_i,
   input  logic [DATA_W-1:0] imm_i,
   input  logic              c_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o,
   output logic              c_upd_o,
   output logic              lit_o,
   output logic              known_o
);

   logic              cin_eff;
   logic [DATA_W:0]   sum;

   generate
      if (HAS_ADDC) begin : g_addc
         assign cin_eff = (op_i == OP_ADDC) & c_i;
      end else begin : g_no_addc
         assign cin_eff = 1'b0;
      end
   endgenerate

   assign sum = {1'b0, w_i} + {1'b0, f_i} + {{DATA_W{1'b0}}, cin_eff};

   always_comb begin
      res_o   = '0;
      c_o     = 1'b0;
      c_upd_o = 1'b0;
      lit_o   = 1'b0;
      known_o = 1'b1;
      case (op_i)
         OP_MOV: res_o = f_i;
         OP_ADD, OP_ADDC: begin
            res_o   = sum[DATA_W-1:0];
            c_o     = sum[DATA_W];
            c_upd_o = 1'b1;
         end
         OP_DEC: res_o = f_i - DATA_W'(1);
         OP_LDW: begin
            res_o = imm_i;
            lit_o = 1'b1;
         end
         default: known_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  sel;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_sel
         assign sel[g] = we_i && (addr_i == ADDR_W'(g));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (sel[i]) mem[i] <= wdata_i;
         end
      end
   end

   assign rdata_o = mem[addr_i];

endmodule

// File: rtl/acc_byte_unit.sv
module acc_byte_unit
   import acc_unit_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 16,
   parameter bit HAS_ADDC = 1'b1,
   localparam int ADDR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic [ADDR_W-1:0] faddr,
   input  logic              dest,
   input  logic [DATA_W-1:0] imm,
   output logic [DATA_W-1:0] w_out,
   output logic [DATA_W-1:0] result,
   output logic              carry,
   output logic              zero,
   output logic              done
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("acc_byte_unit: DATA_W must be at least 2");
      end
      if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("acc_byte_unit: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] w_q, res_q, rd_byte, alu_res;
   logic              c_q, z_q, done_q;
   logic              alu_c, alu_cupd, alu_lit, alu_known;
   logic              act, wr_w, wr_f;

   acc_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (faddr),
      .we_i    (wr_f),
      .wdata_i (alu_res),
      .rdata_o (rd_byte)
   );

   acc_alu #(.DATA_W(DATA_W), .HAS_ADDC(HAS_ADDC)) u_alu (
      .op_i    (op),
      .w_i     (w_q),
      .f_i     (rd_byte),
      .imm_i   (imm),
      .c_i     (c_q),
      .res_o   (alu_res),
      .c_o     (alu_c),
      .c_upd_o (alu_cupd),
      .lit_o   (alu_lit),
      .known_o (alu_known)
   );

   assign act  = start && alu_known;
   assign wr_w = act && (alu_lit || !dest);
   assign wr_f = act && !alu_lit && dest;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q    <= '0;
         res_q  <= '0;
         c_q    <= 1'b0;
         z_q    <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= start;
         if (act) begin
            res_q <= alu_res;
            z_q   <= (alu_res == '0);
         end
         if (act && alu_cupd) c_q <= alu_c;
         if (wr_w) w_q <= alu_res;
      end
   end

   assign w_out  = w_q;
   assign result = res_q;
   assign carry  = c_q;
   assign zero   = z_q;
   assign done   = done_q;

endmodule

// File: rtl/acc_byte_unit_chk.sv
module acc_byte_unit_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [2:0]        op,
   input logic              dest,
   input logic [DATA_W-1:0] imm,
   input logic [DATA_W-1:0] rd_byte,
   input logic [DATA_W-1:0] w_out,
   input logic [DATA_W-1:0] result,
   input logic              carry,
   input logic              zero,
   input logic              done
);

   assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);

   assert_done_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start));

   assert_add_into_w_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 3'd1 && !dest) |=>
         ({carry, w_out} == ({1'b0, $past(w_out)} + {1'b0, $past(rd_byte)})));

   assert_file_dest_keeps_w_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && dest && op <= 3'd3) |=> $stable(w_out));

   assert_carry_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (op == 3'd0 || op == 3'd3 || op == 3'd4)) |=> $stable(carry));

   assert_zero_tracks_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op <= 3'd4) |=> (zero == (result == '0)));

   assert_literal_to_w_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 3'd4) |=> (w_out == $past(imm)));

   assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!start || op > 3'd4) |=>
         ($stable(w_out) && $stable(carry) && $stable(zero) && $stable(result)));

endmodule

bind acc_byte_unit acc_byte_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .op      (op),
   .dest    (dest),
   .imm     (imm),
   .rd_byte (rd_byte),
   .w_out   (w_out),
   .result  (result),
   .carry   (carry),
   .zero    (zero),
   .done    (done)
);

// File: tb/acc_byte_unit_test.sv
module acc_byte_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] op = 3'd0;
   logic [3:0] faddr = 4'd0;
   logic       dest = 1'b0;
   logic [7:0] imm = 8'd0;
   logic [7:0] w_out, result;
   logic       carry, zero, done;

   int checks = 0;
   int failures = 0;

   logic [7:0] m_file [16];
   logic [7:0] m_w, m_res;
   logic       m_c, m_z;

   always #5 clk = ~clk;

   acc_byte_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .faddr(faddr),
      .dest(dest), .imm(imm), .w_out(w_out), .result(result),
      .carry(carry), .zero(zero), .done(done)
   );

   function automatic string req_of(input logic [2:0] o);
      case (o)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [8:0] add9(input logic [7:0] a, input logic [7:0] b,
                                       input logic ci);
      return {1'b0, a} + {1'b0, b} + {8'd0, ci};
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=0x%0h exp=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_state(input string tag);
      check(w_out == m_w, tag, "w_out", w_out, m_w);
      check(carry == m_c, tag == "R4" || tag == "R5" ? tag : "R7", "carry", carry, m_c);
      check(zero == m_z, tag == "R10" ? tag : "R8", "zero", zero, m_z);
      check(result == m_res, tag == "R10" ? tag : "R11", "result", result, m_res);
   endtask

   task automatic run_op(input logic [2:0] o, input logic [3:0] a, input logic d,
                         input logic [7:0] li);
      logic [7:0] f, r;
      logic [8:0] s;
      logic       cc;
      @(negedge clk);
      start = 1'b1; op = o; faddr = a; dest = d; imm = li;
      f = m_file[a]; r = 8'd0; cc = m_c;
      case (o)
         3'd0: r = f;
         3'd1: begin s = add9(m_w, f, 1'b0); r = s[7:0]; cc = s[8]; end
         3'd2: begin s = add9(m_w, f, m_c); r = s[7:0]; cc = s[8]; end
         3'd3: r = f - 8'd1;
         3'd4: r = li;
         default: r = 8'd0;
      endcase
      @(negedge clk);
      start = 1'b0;
      if (o <= 3'd4) begin
         m_res = r;
         m_z = (r == 8'd0);
         m_c = cc;
         if (o == 3'd4 || !d) m_w = r;
         else m_file[a] = r;
      end
      check(done == 1'b1, "R2", "done after start", done, 1);
      check_state(req_of(o));
   endtask

   task automatic idle_check();
      @(negedge clk);
      check(done == 1'b0, "R2", "done when idle", done, 0);
      check_state("R10");
   endtask

   // reads a file byte through a move into W and checks it against the model
   task automatic read_back(input logic [3:0] a, input string tag);
      logic [7:0] exp;
      exp = m_file[a];
      run_op(3'd0, a, 1'b0, 8'd0);
      check(w_out == exp, tag, "file byte read back", w_out, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL R2 watchdog expired act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int seed_sink;
      seed_sink = $urandom(32'h5EED_1234);
      for (int i = 0; i < 16; i++) m_file[i] = 8'd0;
      m_w = 8'd0; m_res = 8'd0; m_c = 1'b0; m_z = 1'b0;

      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(w_out == 8'd0 && carry == 1'b0 && zero == 1'b0 && result == 8'd0 && done == 1'b0,
            "R1", "reset outputs", {w_out, result, 3'b0, carry, zero, done}, 0);
      rst_n = 1'b1;
      idle_check();
      for (int i = 0; i < 16; i++) read_back(4'(i), "R1");

      // R9: literal into W, dest ignored
      run_op(3'd4, 4'd3, 1'b1, 8'hFF);
      read_back(4'd3, "R9");
      run_op(3'd4, 4'd3, 1'b0, 8'hFF);
      // R4: add to file, W held
      run_op(3'd1, 4'd3, 1'b1, 8'h00);
      read_back(4'd3, "R4");
      // R4/R8: overflow to zero with carry
      run_op(3'd4, 4'd0, 1'b0, 8'h01);
      run_op(3'd1, 4'd3, 1'b0, 8'h00);
      check(zero == 1'b1 && carry == 1'b1, "R8", "0xFF+1 flags", {carry, zero}, 3);
      // R7: decrement keeps carry, wraps 0 to 0xFF
      run_op(3'd3, 4'd7, 1'b0, 8'h00);
      check(w_out == 8'hFF && carry == 1'b1, "R6", "dec wrap", {carry, w_out}, 9'h1FF);
      run_op(3'd3, 4'd7, 1'b1, 8'h00);
      read_back(4'd7, "R6");
      // R5: two-byte chain 0x01FF + 0x0001 = 0x0200
      run_op(3'd4, 4'd0, 1'b0, 8'hFF);
      run_op(3'd1, 4'd8, 1'b1, 8'h00);
      run_op(3'd4, 4'd0, 1'b0, 8'h01);
      run_op(3'd1, 4'd9, 1'b1, 8'h00);
      run_op(3'd4, 4'd0, 1'b0, 8'h01);
      run_op(3'd1, 4'd8, 1'b1, 8'h00);
      run_op(3'd4, 4'd0, 1'b0, 8'h00);
      run_op(3'd2, 4'd9, 1'b1, 8'h00);
      read_back(4'd8, "R5");
      read_back(4'd9, "R5");
      // R10: undefined opcodes with file destination
      run_op(3'd5, 4'd9, 1'b1, 8'h55);
      run_op(3'd7, 4'd9, 1'b0, 8'h55);
      read_back(4'd9, "R10");
      // R3: move with file destination
      run_op(3'd0, 4'd9, 1'b1, 8'h00);
      read_back(4'd9, "R3");

      for (int n = 0; n < 600; n++) begin
         logic [2:0] o;
         o = 3'($urandom_range(0, 7));
         run_op(o, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                8'($urandom_range(0, 255)));
         if ($urandom_range(0, 7) == 0) idle_check();
      end
      for (int i = 0; i < 16; i++) read_back(4'(i), "R4");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule